// File: doc/BRIEF.md
# Fixed-Field Form Checker

This block sits on the receive side of a controller for a CAN XL-style bus. A frame sequencer sends it each sampled bus bit with a sample strobe and a small field code. The code says which kind of frame position the bit belongs to. At positions whose value is fixed by the frame format, the block compares the sampled bit with the defined value. On a mismatch it raises a one-cycle form-error pulse. Bit timing, stuffing and CRC are handled elsewhere. The block only judges the fixed positions.

The block handles four kinds of position in their own way:

- **Reserved bit.** The bit after the XL format bit is expected dominant. A recessive value raises a form error, or, if a configuration pin selects it, moves the block into a protocol-exception state. That state lasts until the bus is reported idle.
- **Arbitration format bits.** As a transmitter, the node sends its two format-selection bits recessive. Seeing either of them dominant means arbitration is lost.
- **Mode-switch bits.** The two bits where the transceiver changes mode are never checked.
- **Format check pattern.** This 8-bit pattern is checked bit by bit, so that a receiver that has slipped up to three bit positions is caught.

Sample input is a one-way stream qualified by `smp_valid`. The block has no ready signal. It accepts a sample on every cycle and never applies back-pressure, so the sequencer may strobe on any cycle. Outputs are registered and appear in the cycle after the strobe.

Top module: `ffc_top`

## Requirements
- R1: After reset, and until the first strobe, `form_error`, `arb_lost` and `in_exception` are all low.
- R2: Bus levels are 1 for recessive and 0 for dominant. The field codes are:
  - 0: variable bit
  - 1: fixed recessive (delimiters, end of frame)
  - 2: fixed dominant
  - 3: reserved bit after the XL format bit
  - 4: arbitration format bit (FDF/XLF)
  - 5: transceiver mode-switch bit
  - 6: format check pattern
  - 7: spare

  A strobed bit with code 1 sampled 0, or code 2 sampled 1, gives a `form_error` pulse in the next cycle. A matching value gives none. Codes 0 and 7 never give one.
- R3: A cycle without `smp_valid` produces no `form_error` and no `arb_lost` in the following cycle, whatever the other inputs are.
- R4: With `cfg_rsv_exc` = 0, a code-3 bit sampled 1 gives a `form_error` pulse. Sampled 0, it gives nothing.
- R5: With `cfg_rsv_exc` = 1, a code-3 bit sampled 1 gives no `form_error`. Instead, `in_exception` goes high in the next cycle. It stays high until a clock edge at which `bus_idle` is 1, and reads low after that edge.
- R6: While `in_exception` is high, strobes raise neither `form_error` nor `arb_lost`.
- R7: With `is_tx` = 1, a code-4 bit sampled 0 gives an `arb_lost` pulse in the next cycle. Sampled 1 gives nothing. With `is_tx` = 0, code 4 gives nothing.
- R8: Code-5 bits are never checked, whatever their value.
- R9: Consecutive code-6 strobes form the pattern. The first four expect 1, the next four expect 0, and any further code-6 strobes expect 0. Each mismatch gives a `form_error` pulse. Any strobe with another code restarts the count at the first pattern bit.
- R10: If the pattern bits are received shifted by 1, 2 or 3 positions in either direction, at least one `form_error` pulse occurs within the 8 pattern strobes.
- R11: If `bus_idle` is 1 in the same cycle as a strobe that enters the exception state, entry wins and `in_exception` reads high afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe; qualifies `smp_bit` and `fld_code` |
| smp_bit | input | 1 | Sampled bus level, 1 = recessive |
| fld_code | input | 3 | Field code of the sampled bit (see R2) |
| is_tx | input | 1 | Node is currently transmitting the frame |
| cfg_rsv_exc | input | 1 | 1 = a recessive reserved bit enters the exception state; 0 = it is a form error |
| bus_idle | input | 1 | Bus idle indication; clears the exception state |
| form_error | output | 1 | One-cycle form-error pulse |
| arb_lost | output | 1 | One-cycle arbitration-lost pulse |
| in_exception | output | 1 | Protocol-exception state level |

## Verification
Entry into the exception state and its clearing by `bus_idle` can fall in the same cycle. The bench provokes this by strobing a recessive reserved bit with the exception option set and `bus_idle` held high. It judges the outcome by checking that `in_exception` reads high after that edge and low only after a later idle edge. A second overlap is also tested: a strobe that would otherwise be a form error or a lost arbitration arrives while the state is active, and the bench checks that both pulses stay low.

// File: rtl/ffc_pkg.sv
package ffc_pkg;

  localparam logic LVL_REC = 1'b1;
  localparam logic LVL_DOM = 1'b0;

  typedef enum logic [2:0] {
    FLD_VAR     = 3'd0,
    FLD_FIX_REC = 3'd1,
    FLD_FIX_DOM = 3'd2,
    FLD_RSV     = 3'd3,
    FLD_ARB     = 3'd4,
    FLD_SWITCH  = 3'd5,
    FLD_FCP     = 3'd6,
    FLD_SPARE   = 3'd7
  } fld_code_t;

  typedef struct packed {
    logic chk_form;  // compare against exp_bit
    logic chk_arb;   // transmitter arbitration check
    logic chk_rsv;   // reserved-bit handling
    logic exp_bit;   // expected level
  } expect_t;

endpackage

// File: rtl/ffc_fcp_pos.sv
module ffc_fcp_pos #(
  parameter int HI_BITS = 4,
  parameter int LO_BITS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic restart,
  output logic exp_bit
);
  localparam int TOTAL = HI_BITS + LO_BITS;
  localparam int IW    = $clog2(TOTAL + 1);
  localparam logic [IW-1:0] LAST = IW'(TOTAL - 1);
  localparam logic [IW-1:0] HI_N = IW'(HI_BITS);

  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx <= '0;
    else if (restart)  idx <= '0;
    else if (step && idx != LAST) idx <= idx + 1'b1;
  end

  assign exp_bit = (idx < HI_N) ? ffc_pkg::LVL_REC : ffc_pkg::LVL_DOM;

  // R9: a restart always brings the next pattern bit back to recessive
  assert_restart_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> exp_bit == ffc_pkg::LVL_REC);

endmodule

// File: rtl/ffc_expect.sv
module ffc_expect
  import ffc_pkg::*;
(
  input  fld_code_t code,
  input  logic      fcp_bit,
  input  logic      is_tx,
  output expect_t   exp_o
);
  always_comb begin
    exp_o = '{chk_form: 1'b0, chk_arb: 1'b0, chk_rsv: 1'b0, exp_bit: LVL_REC};
    unique case (code)
      FLD_FIX_REC: begin exp_o.chk_form = 1'b1; exp_o.exp_bit = LVL_REC; end
      FLD_FIX_DOM: begin exp_o.chk_form = 1'b1; exp_o.exp_bit = LVL_DOM; end
      FLD_RSV:     begin exp_o.chk_rsv  = 1'b1; exp_o.exp_bit = LVL_DOM; end
      FLD_ARB:     begin exp_o.chk_arb  = is_tx; exp_o.exp_bit = LVL_REC; end
      FLD_FCP:     begin exp_o.chk_form = 1'b1; exp_o.exp_bit = fcp_bit; end
      FLD_VAR, FLD_SWITCH, FLD_SPARE: exp_o.chk_form = 1'b0;
      default:     exp_o.chk_form = 1'b0;
    endcase
  end
endmodule

// File: rtl/ffc_exc_state.sv
module ffc_exc_state (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic idle,
  output logic in_exc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     in_exc <= 1'b0;
    else if (enter) in_exc <= 1'b1;   // entry outranks idle
    else if (idle)  in_exc <= 1'b0;
  end

  // R5: the state is left only through an idle bus
  assert_hold_until_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exc && !idle) |=> in_exc);

  // R11: entry wins over a simultaneous idle
  assert_entry_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> in_exc);

endmodule

// File: rtl/ffc_top.sv
module ffc_top
  import ffc_pkg::*;
#(
  parameter int FCP_HI = 4,
  parameter int FCP_LO = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_valid,
  input  logic       smp_bit,
  input  logic [2:0] fld_code,
  input  logic       is_tx,
  input  logic       cfg_rsv_exc,
  input  logic       bus_idle,
  output logic       form_error,
  output logic       arb_lost,
  output logic       in_exception
);
  fld_code_t code;
  expect_t   exp_s;
  logic      fcp_bit, active, is_fcp, rsv_rec;
  logic      fe_d, al_d, enter;

  assign code = fld_code_t'(fld_code);
  assign is_fcp = (code == FLD_FCP);

  ffc_fcp_pos #(.HI_BITS(FCP_HI), .LO_BITS(FCP_LO)) u_fcp (
    .clk(clk), .rst_n(rst_n),
    .step(smp_valid && is_fcp),
    .restart(smp_valid && !is_fcp),
    .exp_bit(fcp_bit)
  );

  ffc_expect u_exp (
    .code(code), .fcp_bit(fcp_bit), .is_tx(is_tx), .exp_o(exp_s)
  );

  assign active  = smp_valid && !in_exception;
  assign rsv_rec = exp_s.chk_rsv && (smp_bit == LVL_REC);
  assign fe_d    = active && ((exp_s.chk_form && (smp_bit != exp_s.exp_bit)) ||
                              (rsv_rec && !cfg_rsv_exc));
  assign al_d    = active && exp_s.chk_arb && (smp_bit == LVL_DOM);
  assign enter   = active && rsv_rec && cfg_rsv_exc;

  ffc_exc_state u_exc (
    .clk(clk), .rst_n(rst_n), .enter(enter), .idle(bus_idle), .in_exc(in_exception)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      form_error <= 1'b0;
      arb_lost   <= 1'b0;
    end else begin
      form_error <= fe_d;
      arb_lost   <= al_d;
    end
  end

  // R3: pulses only follow a strobe
  assert_pulse_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (form_error || arb_lost) |-> $past(smp_valid));

  // R6: quiet while in the exception state
  assert_quiet_in_exc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_exception) |-> (!form_error && !arb_lost));

  // R7: arbitration loss only for a transmitter seeing dominant
  assert_arb_tx_dom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> ($past(is_tx) && !$past(smp_bit)));

  // R8: mode-switch bits never flagged
  assert_switch_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && fld_code == 3'd5) |=> !form_error);

  // R5: entering the exception state is not a form error
  assert_entry_no_fe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_exception) |-> !form_error);

endmodule

// File: tb/sim_ffc_top.sv
module sim_ffc_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0, smp_bit = 1'b1, is_tx = 1'b0, cfg_rsv_exc = 1'b0, bus_idle = 1'b0;
  logic [2:0] fld_code = 3'd0;
  logic form_error, arb_lost, in_exception;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  ffc_top u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_bit(smp_bit),
    .fld_code(fld_code), .is_tx(is_tx), .cfg_rsv_exc(cfg_rsv_exc), .bus_idle(bus_idle),
    .form_error(form_error), .arb_lost(arb_lost), .in_exception(in_exception)
  );

  // vector: req[19:16] v[15] code[14:12] bit[11] tx[10] cfg[9] idle[8] fe[2] al[1] exc[0]
  function automatic logic [19:0] mk(int rq, bit v, int cd, bit b, bit tx, bit cf, bit id,
                                     bit fe, bit al, bit ex);
    return {4'(rq), v, 3'(cd), b, tx, cf, id, 5'd0, fe, al, ex};
  endfunction

  localparam int NV = 50;
  localparam logic [19:0] VEC [NV] = '{
    mk(2,1,1,0,0,0,0, 1,0,0),  // R2 fixed recessive seen dominant
    mk(2,1,1,1,0,0,0, 0,0,0),  // R2 match
    mk(2,1,2,1,0,0,0, 1,0,0),  // R2 fixed dominant seen recessive
    mk(2,1,2,0,0,0,0, 0,0,0),  // R2 match
    mk(3,0,1,0,1,0,0, 0,0,0),  // R3 no strobe
    mk(3,0,4,0,1,0,0, 0,0,0),  // R3 no strobe, tx arb bit
    mk(4,1,3,1,0,0,0, 1,0,0),  // R4 reserved recessive
    mk(4,1,3,0,0,0,0, 0,0,0),  // R4 reserved dominant
    mk(7,1,4,0,1,0,0, 0,1,0),  // R7 tx sees dominant
    mk(7,1,4,1,1,0,0, 0,0,0),  // R7 tx recessive
    mk(7,1,4,0,0,0,0, 0,0,0),  // R7 receiver ignores
    mk(8,1,5,0,0,0,0, 0,0,0),  // R8 switch bit dominant
    mk(8,1,5,1,0,0,0, 0,0,0),  // R8 switch bit recessive
    mk(2,1,0,0,0,0,0, 0,0,0),  // R2 variable bit
    mk(2,1,7,0,0,0,0, 0,0,0),  // R2 spare code
    mk(9,1,6,1,0,0,0, 0,0,0),  // R9 correct pattern
    mk(9,1,6,1,0,0,0, 0,0,0),
    mk(9,1,6,1,0,0,0, 0,0,0),
    mk(9,1,6,1,0,0,0, 0,0,0),
    mk(9,1,6,0,0,0,0, 0,0,0),
    mk(9,1,6,0,0,0,0, 0,0,0),
    mk(9,1,6,0,0,0,0, 0,0,0),
    mk(9,1,6,0,0,0,0, 0,0,0),
    mk(9,1,6,0,0,0,0, 0,0,0),  // R9 beyond window expects dominant
    mk(9,1,6,1,0,0,0, 1,0,0),
    mk(9,1,0,0,0,0,0, 0,0,0),  // R9 restart
    mk(9,1,6,1,0,0,0, 0,0,0),
    mk(9,1,6,1,0,0,0, 0,0,0),
    mk(9,1,0,1,0,0,0, 0,0,0),  // R9 restart mid-pattern
    mk(9,1,6,1,0,0,0, 0,0,0),
    mk(9,1,6,0,0,0,0, 1,0,0),  // R9 idx1 expects recessive
    mk(2,1,0,0,0,0,0, 0,0,0),
    mk(10,1,6,0,0,0,0, 1,0,0), // R10 late by one
    mk(10,1,6,1,0,0,0, 0,0,0),
    mk(10,1,6,1,0,0,0, 0,0,0),
    mk(10,1,6,1,0,0,0, 0,0,0),
    mk(10,1,6,1,0,0,0, 1,0,0),
    mk(10,1,6,0,0,0,0, 0,0,0),
    mk(5,1,3,0,0,1,0, 0,0,0),  // R5 dominant reserved, option set
    mk(5,1,3,1,0,1,0, 0,0,1),  // R5 enter exception
    mk(6,1,1,0,0,0,0, 0,0,1),  // R6 form check suppressed
    mk(6,1,4,0,1,0,0, 0,0,1),  // R6 arbitration suppressed
    mk(6,1,3,1,0,0,0, 0,0,1),  // R6 reserved suppressed
    mk(5,0,0,0,0,0,0, 0,0,1),  // R5 holds
    mk(5,0,0,0,0,0,1, 0,0,0),  // R5 idle clears
    mk(5,1,1,0,0,0,0, 1,0,0),  // R5 checks resume
    mk(11,1,3,1,0,1,1, 0,0,1), // R11 entry with idle
    mk(11,0,0,0,0,0,0, 0,0,1), // R11 still held
    mk(11,0,0,0,0,0,1, 0,0,0), // R11 later idle clears
    mk(1,0,0,1,0,0,0, 0,0,0)
  };

  task automatic chk(string rq, string what, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b", rq, what, got, exp);
    end
  endtask

  task automatic step(bit v, int cd, bit b, bit tx, bit cf, bit id);
    @(negedge clk);
    smp_valid = v; fld_code = 3'(cd); smp_bit = b; is_tx = tx; cfg_rsv_exc = cf; bus_idle = id;
    @(posedge clk);
    #2;
  endtask

  function automatic bit ext_bit(int j);
    if (j < 0) return 1'b0;
    if (j < 4) return 1'b1;
    if (j < 8) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "form_error in reset", form_error, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1", "form_error", form_error, 1'b0);
    chk("R1", "arb_lost", arb_lost, 1'b0);
    chk("R1", "in_exception", in_exception, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [19:0] w;
      string rq;
      w = VEC[i];
      rq = $sformatf("R%0d(vec %0d)", w[19:16], i);
      step(w[15], int'(w[14:12]), w[11], w[10], w[9], w[8]);
      chk(rq, "form_error", form_error, w[2]);
      chk(rq, "arb_lost", arb_lost, w[1]);
      chk(rq, "in_exception", in_exception, w[0]);
    end

    // R10: shifted patterns in both directions must be caught
    for (int s = -3; s <= 3; s++) begin
      int hits;
      if (s == 0) continue;
      hits = 0;
      step(1, 0, 1, 0, 0, 0);
      for (int k = 0; k < 8; k++) begin
        step(1, 6, ext_bit(k + s), 0, 0, 0);
        if (form_error) hits++;
      end
      chk("R10", $sformatf("slip %0d detected", s), hits > 0, 1'b1);
    end

    step(0, 0, 1, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule